// File: doc/BRIEF.md
# Block-Granular SRAM Security Gate

This gate sits in the path from a bus master to a 64 KB SRAM and decides, for every transfer, whether the transfer may reach the memory. The address space is divided into 256-byte blocks. A bitmap holds one bit per block, and a set bit marks that block as reachable only by secure transfers. A non-secure transfer that lands on a secure block is stopped at the gate and never reaches the SRAM. The gate answers it with an error response, and a sticky violation event is raised that software later clears.

The bitmap is held in 32-bit map words, with one word per 8 KB group of 32 blocks. A lock register carries one bit per group. Once a lock bit is set, it freezes the matching map word until reset. Only secure accesses may use the configuration port. A non-secure configuration access changes nothing, returns an error, and raises its own sticky event. After reset every block is secure and nothing is locked.

Top module: `sram_sec_gate`

## Requirements
- R1: After reset, every map word reads 0xFFFFFFFF, so all blocks are secure. The lock register reads 0, the status register reads 0, and both event outputs are low.
- R2: The block index of a transfer is req_addr[15:8]. Block b is governed by bit b%32 of map word b/32, and map word j sits at configuration index j (0 to 7).
- R3: A secure transfer is forwarded to the memory port (mem_en high in the same cycle) whatever the map says. A non-secure transfer to a block whose map bit is 0 is also forwarded.
- R4: A non-secure transfer to a block whose map bit is 1 is blocked. mem_en stays low, so a write leaves memory unchanged, and the response carries rsp_err=1 with rsp_rdata=0.
- R5: Every request gets exactly one response, with rsp_valid high in the cycle after the request. rsp_err is 1 only for blocked transfers, and a forwarded read returns the memory data.
- R6: A blocked transfer sets xfer_irq (status bit 0) from the next cycle. The bit stays set until a secure write to the status index (8+1 = 9) with bit 0 set clears it.
- R7: The lock register is at index 8. A write ORs the written bits [7:0] into it, so no write can clear a lock bit; only reset can. While lock bit j is set, writes to map word j are ignored.
- R8: A non-secure configuration access is ignored. It answers one cycle later with cfg_err=1 and cfg_rdata=0, and it sets cfg_irq (status bit 1). A secure write to index 9 with bit 1 set clears cfg_irq.
- R9: A secure configuration read returns the addressed register on cfg_rdata in the next cycle. The status register reads {cfg_irq, xfer_irq} in bits [1:0]. A configuration write takes effect for transfers starting the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the transfer (1 = secure) |
| req_addr | input | 16 | Byte address in the SRAM |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Response is a security error |
| rsp_rdata | output | 32 | Read data (zero on error) |
| mem_en | output | 1 | Forwarded access strobe to the SRAM |
| mem_we | output | 1 | Forwarded write enable |
| mem_addr | output | 16 | Forwarded address |
| mem_wdata | output | 32 | Forwarded write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after mem_en |
| cfg_valid | input | 1 | Configuration access present |
| cfg_write | input | 1 | 1 = configuration write |
| cfg_secure | input | 1 | Security attribute of the configuration access |
| cfg_addr | input | 4 | Register index: 0-7 map words, 8 lock, 9 status/clear |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data, one cycle after the access |
| cfg_err | output | 1 | Previous configuration access was non-secure |
| xfer_irq | output | 1 | Sticky blocked-transfer event |
| cfg_irq | output | 1 | Sticky illegal-configuration-access event |

## Verification
The forwarding decision on mem_en is combinational, so the bench samples it one time step after driving the request, before the clock edge. The transfer response, the configuration read data, cfg_err and both event bits all come from a register, so they are sampled at the falling edge one full cycle after the stimulus edge. A map or lock write is always followed by at least one idle edge before a transfer relies on it. Expected values come from a shadow copy of the map, lock, events and memory that the bench updates only by the rules in the requirements.

// File: rtl/sram_sec_gate.sv
module sram_sec_gate #(
  parameter int ADDR_W = 16,
  parameter int BLK_W  = 8,
  parameter int DATA_W = 32,
  parameter int CFG_AW = $clog2((1 << (ADDR_W - BLK_W)) / 32 + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_valid,
  input  logic              cfg_write,
  input  logic              cfg_secure,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_err,
  output logic              xfer_irq,
  output logic              cfg_irq
);
  localparam int IDX_W = ADDR_W - BLK_W;
  localparam int NBLK  = 1 << IDX_W;
  localparam int NWORD = NBLK / 32;
  localparam logic [CFG_AW-1:0] LOCK_IDX = CFG_AW'(NWORD);
  localparam logic [CFG_AW-1:0] STAT_IDX = CFG_AW'(NWORD + 1);

  logic [NBLK-1:0]  secmap;
  logic [NWORD-1:0] lock;
  logic [31:0]      rd_mux;

  wire [IDX_W-1:0] blk = req_addr[ADDR_W-1:BLK_W];
  wire blocked  = req_valid & ~req_secure & secmap[blk];
  wire cfg_ok   = cfg_valid & cfg_secure;
  wire cfg_bad  = cfg_valid & ~cfg_secure;
  wire clr_hit  = cfg_ok & cfg_write & (cfg_addr == STAT_IDX);

  assign mem_en    = req_valid & ~blocked;
  assign mem_we    = req_write;
  assign mem_addr  = req_addr;
  assign mem_wdata = req_wdata;
  assign rsp_rdata = (rsp_valid && !rsp_err) ? mem_rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= blocked;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secmap <= '1;
      lock   <= '0;
    end else if (cfg_ok && cfg_write) begin
      if (cfg_addr == LOCK_IDX) lock <= lock | cfg_wdata[NWORD-1:0];
      for (int j = 0; j < NWORD; j++)
        if (cfg_addr == CFG_AW'(j) && !lock[j]) secmap[32*j +: 32] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_irq <= 1'b0;
      cfg_irq  <= 1'b0;
    end else begin
      xfer_irq <= blocked | (xfer_irq & ~(clr_hit & cfg_wdata[0]));
      cfg_irq  <= cfg_bad | (cfg_irq & ~(clr_hit & cfg_wdata[1]));
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int j = 0; j < NWORD; j++)
      if (cfg_addr == CFG_AW'(j)) rd_mux = secmap[32*j +: 32];
    if (cfg_addr == LOCK_IDX) rd_mux = 32'(lock);
    if (cfg_addr == STAT_IDX) rd_mux = {30'b0, cfg_irq, xfer_irq};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rdata <= '0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_rdata <= (cfg_ok && !cfg_write) ? rd_mux : '0;
      cfg_err   <= cfg_bad;
    end
  end

  // R3
  secure_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_secure) |-> mem_en);

  // R4
  blocked_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_en) |=> (rsp_err && rsp_rdata == '0));

  // R5
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R5
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R6
  xfer_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_irq) |-> $past(req_valid && !req_secure && !mem_en));

  // R8
  cfg_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_secure) |=> (cfg_err && cfg_irq && cfg_rdata == '0));

  for (genvar g = 0; g < NWORD; g++) begin : g_lock_chk
    // R7
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock[g] |=> lock[g]);
    // R7
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock[g] |=> $stable(secmap[32*g +: 32]));
  end
endmodule

// File: tb/tb_sram_sec_gate.sv
module tb_sram_sec_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_secure = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        mem_en, mem_we;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic        cfg_valid = 0, cfg_write = 0, cfg_secure = 0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err, xfer_irq, cfg_irq;

  int nchk = 0, nerr = 0;
  bit done = 0;

  logic [31:0]  sram [1024];
  logic [31:0]  sh_mem [1024];
  logic [255:0] sh_map = '1;
  logic [7:0]   sh_lock = '0;
  bit           sh_x = 0, sh_c = 0;

  always #10 clk = ~clk;

  sram_sec_gate dut (
    .clk, .rst_n, .req_valid, .req_write, .req_secure, .req_addr, .req_wdata,
    .rsp_valid, .rsp_err, .rsp_rdata, .mem_en, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .cfg_valid, .cfg_write, .cfg_secure, .cfg_addr, .cfg_wdata,
    .cfg_rdata, .cfg_err, .xfer_irq, .cfg_irq
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) sram[mem_addr[11:2]] <= mem_wdata;
      mem_rdata <= sram[mem_addr[11:2]];
    end
  end

  function automatic logic [31:0] exp_reg(int idx);
    if (idx < 8) return sh_map[idx*32 +: 32];
    if (idx == 8) return {24'b0, sh_lock};
    if (idx == 9) return {30'b0, sh_c, sh_x};
    return '0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(bit we, bit sec, logic [15:0] a, logic [31:0] wd);
    bit blk = !sec && sh_map[a[15:8]];
    @(negedge clk);
    req_valid = 1; req_write = we; req_secure = sec; req_addr = a; req_wdata = wd;
    #1;
    chk(blk ? "R4 gated mem_en" : "R3 forwarded mem_en", 32'(mem_en), 32'(!blk));
    @(negedge clk);
    req_valid = 0;
    chk("R5 rsp_valid", 32'(rsp_valid), 1);
    chk("R5 rsp_err", 32'(rsp_err), 32'(blk));
    if (!we) chk(blk ? "R4 blocked read data" : "R5 read data", rsp_rdata, blk ? 32'h0 : sh_mem[a[11:2]]);
    if (blk) sh_x = 1;
    else if (we) sh_mem[a[11:2]] = wd;
    chk("R6 xfer_irq", 32'(xfer_irq), 32'(sh_x));
  endtask

  task automatic cfg(bit wr, bit sec, int idx, logic [31:0] wd);
    logic [31:0] exp = (sec && !wr) ? exp_reg(idx) : 32'h0;
    @(negedge clk);
    cfg_valid = 1; cfg_write = wr; cfg_secure = sec; cfg_addr = 4'(idx); cfg_wdata = wd;
    @(negedge clk);
    cfg_valid = 0;
    chk("R8 cfg_err", 32'(cfg_err), 32'(!sec));
    chk(sec ? "R9 cfg_rdata" : "R8 ignored read data", cfg_rdata, exp);
    if (!sec) sh_c = 1;
    else if (wr) begin
      if (idx < 8 && !sh_lock[idx]) sh_map[idx*32 +: 32] = wd;
      if (idx == 8) sh_lock = sh_lock | wd[7:0];
      if (idx == 9) begin
        if (wd[0]) sh_x = 0;
        if (wd[1]) sh_c = 0;
      end
    end
    chk("R8 cfg_irq", 32'(cfg_irq), 32'(sh_c));
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0A11));
    for (int i = 0; i < 1024; i++) begin
      sram[i] = 32'hA5000000 ^ 32'(i * 7919);
      sh_mem[i] = sram[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 xfer_irq", 32'(xfer_irq), 0);
    chk("R1 cfg_irq", 32'(cfg_irq), 0);
    for (int j = 0; j < 10; j++) cfg(0, 1, j, 0);
    xfer(0, 0, 16'h0000, 0);
    xfer(1, 0, 16'hFFFC, 32'h1111_2222);
    xfer(0, 1, 16'hFFFC, 0);
    cfg(1, 1, 9, 32'h1);
    cfg(0, 1, 9, 0);

    // R2 block index and word mapping: word 3 bit 5 -> block 101
    for (int j = 0; j < 8; j++) cfg(1, 1, j, 32'h0);
    cfg(1, 1, 3, 32'h0000_0020);
    xfer(0, 0, 16'h6500, 0);
    xfer(1, 0, 16'h65FC, 32'hDEAD_BEEF);
    xfer(0, 1, 16'h65FC, 0);
    xfer(0, 0, 16'h64FC, 0);
    xfer(1, 0, 16'h6600, 32'h1234_5678);
    xfer(1, 1, 16'h6504, 32'hCAFE_F00D);
    cfg(0, 1, 9, 0);
    cfg(1, 1, 9, 32'h1);

    // R7 lock freezes word 3, cannot be cleared
    cfg(1, 1, 8, 32'h08);
    cfg(1, 1, 3, 32'h0);
    cfg(0, 1, 3, 0);
    cfg(1, 1, 8, 32'h0);
    cfg(0, 1, 8, 0);
    xfer(0, 0, 16'h6500, 0);
    cfg(1, 1, 2, 32'hFFFF_0000);
    cfg(0, 1, 2, 0);

    // R8 non-secure configuration accesses ignored
    cfg(1, 0, 0, 32'hFFFF_FFFF);
    cfg(0, 1, 0, 0);
    cfg(0, 0, 9, 0);
    cfg(1, 1, 9, 32'h2);
    cfg(0, 1, 9, 0);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 100);
      if (r < 75) xfer(1'($urandom), 1'($urandom % 4 == 0), {$urandom % 65536}[15:0] & 16'hFFFC, $urandom);
      else if (r < 88) cfg(1, 1, int'($urandom % 8), $urandom);
      else if (r < 93) cfg(0, 1'($urandom % 4 != 0), int'($urandom % 10), 0);
      else if (r < 98) cfg(1, 1, 9, $urandom % 4);
      else if (r < 99 && n > 2000) cfg(1, 1, 8, 32'(1 << ($urandom % 8)));
      else cfg(1, 0, int'($urandom % 10), $urandom);
    end
    for (int j = 0; j < 10; j++) cfg(0, 1, j, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule